// File: doc/BRIEF.md
# Dual-Edge Reciprocal Pulse Timer

This block measures the timing of a single external digital signal in system-clock cycles. The incoming level is synchronised and then debounced by a short stability filter. Each accepted rising or falling transition is stamped with the value of a free-running reference count. That count is widened by a second counter that tallies wraps of the base counter, so a single measurement can span many wraps.

Each edge polarity has its own capture channel. A channel keeps its two most recent timestamps in a two-slot buffer whose write slot alternates, and it keeps a running count of captured edges. From the four stored stamps the block derives, every cycle, four intervals: rise-to-rise period, fall-to-fall period, high time and low time. It also raises a ready flag. Software-side conversion to frequency or time units happens elsewhere.

A one-cycle start strobe clears the channels and arms capture. A stop strobe disarms capture but keeps the stored results.

Top module: `dual_edge_pulse_timer`

## Requirements
- R1: The base counter is CNT_W bits wide, counts up by one each cycle and wraps from all ones to zero. Each wrap increments an OVF_W-bit wrap counter. A timestamp is {wrap count, base count} read as a signed value, so intervals that span one or more wraps come out exact. If a wrap and a capture fall in the same cycle, the capture uses the wrap count from before the increment.
- R2: The input goes through a two-flop synchroniser and then a filter. A new level is accepted only after FILT_LEN (2) consecutive identical samples. A high pulse lasting a single cycle produces no edge; a pulse lasting two cycles produces one rise and one fall.
- R3: Each polarity stores captures alternately in slot 0 and slot 1, so the last two timestamps of that polarity are always held.
- R4: Each polarity has an 8-bit edge count that increments on every capture and wraps modulo 256.
- R5: A start strobe clears both buffers and both edge counts on its edge and arms capture. The ready flag reads 0 on the following cycle.
- R6: After a stop strobe, edges are neither stored nor counted until the next start.
- R7: The ready flag is 1 when at least one of the four stored timestamps is non-zero. When ready is 0, all four interval outputs are 0.
- R8: For each polarity, the two stored stamps are ordered by value. The rise period is later rise minus earlier rise, and the fall period is later fall minus earlier fall.
- R9: If the later fall is greater than the later rise, high time is earlier fall minus earlier rise and low time is later rise minus earlier fall.
- R10: Otherwise, high time is later fall minus earlier rise and low time is earlier rise minus earlier fall.
- R11: Any interval whose difference is negative is output as zero, so no interval output ever has its top bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the timing reference |
| rst | input | 1 | Synchronous active-high reset |
| sig_async_i | input | 1 | Asynchronous signal under measurement |
| start_i | input | 1 | Clear-and-arm strobe |
| stop_i | input | 1 | Disarm strobe |
| rise_count_o | output | EC_W | Captured rising edges since start |
| fall_count_o | output | EC_W | Captured falling edges since start |
| period_rise_o | output | CNT_W+OVF_W | Rise-to-rise period in cycles |
| period_fall_o | output | CNT_W+OVF_W | Fall-to-fall period in cycles |
| high_time_o | output | CNT_W+OVF_W | High time in cycles |
| low_time_o | output | CNT_W+OVF_W | Low time in cycles |
| ready_o | output | 1 | Intervals valid |

## Verification
Two events can land on the same clock edge: a wrap of the base counter, which bumps the wrap count, and an edge capture, which reads the joined timestamp. The bench uses an 8-bit base counter and sweeps many periods and duty cycles, including one period longer than a full wrap. As a result, captures fall at every phase relative to the wrap, including the wrap cycle itself. Any mismatch in how the two are combined shows up as an interval that differs from the driven period, high time or low time by a multiple of 256. Each of those intervals is compared against the driven value, which is exact because rising and falling edges see the same pipeline latency.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  localparam int DEF_CNT_W = 32;
  localparam int DEF_OVF_W = 32;
  localparam int DEF_EC_W  = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/pt_timebase.sv
module pt_timebase #(
  parameter int CNT_W = 32,
  parameter int OVF_W = 32,
  localparam int TS_W = CNT_W + OVF_W
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts_o
);
  logic [CNT_W-1:0] base_q;
  logic [OVF_W-1:0] wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      wrap_q <= '0;
    end else begin
      base_q <= base_q + 1'b1;
      if (&base_q) wrap_q <= wrap_q + 1'b1;
    end
  end

  // capture in the wrap cycle sees the old wrap count with base all ones
  assign ts_o = {wrap_q, base_q};

  assert_wrap_step_R1: assert property (@(posedge clk) disable iff (rst)
    (&base_q) |=> (base_q == '0) && (wrap_q == $past(wrap_q) + 1'b1));
  assert_wrap_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(&base_q) |=> $stable(wrap_q));
endmodule

// File: rtl/pt_input_cond.sv
module pt_input_cond
  import pulse_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sig_i,
  output edge_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;
  edge_evt_t              evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
      evt_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sig_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      evt_q  <= '0;
      if ((&hist_q) && !level_q) begin
        level_q    <= 1'b1;
        evt_q.rise <= 1'b1;
      end else if (!(|hist_q) && level_q) begin
        level_q    <= 1'b0;
        evt_q.fall <= 1'b1;
      end
    end
  end

  assign evt_o = evt_q;

  assert_one_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_q.rise, evt_q.fall}));
  assert_rise_level_R2: assert property (@(posedge clk) disable iff (rst)
    evt_q.rise |-> level_q);
  assert_fall_level_R2: assert property (@(posedge clk) disable iff (rst)
    evt_q.fall |-> !level_q);
endmodule

// File: rtl/pt_capture_chan.sv
module pt_capture_chan #(
  parameter int TS_W = 64,
  parameter int EC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            evt_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] slot0_o,
  output logic [TS_W-1:0] slot1_o,
  output logic [EC_W-1:0] count_o
);
  logic [TS_W-1:0] slot_q [2];
  logic            wr_sel_q;
  logic            armed_q;
  logic [EC_W-1:0] count_q;
  logic            cap;

  assign cap = evt_i && armed_q && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      wr_sel_q <= 1'b0;
      count_q  <= '0;
    end else if (start_i) begin
      armed_q  <= 1'b1;
      wr_sel_q <= 1'b0;
      count_q  <= '0;
    end else begin
      if (stop_i) armed_q <= 1'b0;
      if (cap) begin
        wr_sel_q <= ~wr_sel_q;
        count_q  <= count_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || start_i)
        slot_q[g] <= '0;
      else if (cap && (wr_sel_q == 1'(g)))
        slot_q[g] <= ts_i;
    end
  end

  assign slot0_o = slot_q[0];
  assign slot1_o = slot_q[1];
  assign count_o = count_q;

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    cap |=> count_q == $past(count_q) + 1'b1);
  assert_start_clear_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (count_q == '0) && (slot0_o == '0) && (slot1_o == '0));
  assert_disarmed_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !start_i) |=> $stable(count_q) && $stable(slot0_o) && $stable(slot1_o));
  assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    cap |=> wr_sel_q != $past(wr_sel_q));
endmodule

// File: rtl/pt_interval_calc.sv
module pt_interval_calc #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] rise0_i,
  input  logic [TS_W-1:0] rise1_i,
  input  logic [TS_W-1:0] fall0_i,
  input  logic [TS_W-1:0] fall1_i,
  output logic [TS_W-1:0] per_rise_o,
  output logic [TS_W-1:0] per_fall_o,
  output logic [TS_W-1:0] high_o,
  output logic [TS_W-1:0] low_o,
  output logic            ready_o
);
  function automatic logic [TS_W-1:0] nonneg(input logic signed [TS_W-1:0] d);
    return d[TS_W-1] ? '0 : d;
  endfunction

  logic signed [TS_W-1:0] r_early, r_late, f_early, f_late;
  logic signed [TS_W-1:0] d_pr, d_pf, d_hi, d_lo;
  logic                   any_set;

  always_comb begin
    if ($signed(rise0_i) > $signed(rise1_i)) begin
      r_early = $signed(rise1_i);
      r_late  = $signed(rise0_i);
    end else begin
      r_early = $signed(rise0_i);
      r_late  = $signed(rise1_i);
    end
    if ($signed(fall0_i) > $signed(fall1_i)) begin
      f_early = $signed(fall1_i);
      f_late  = $signed(fall0_i);
    end else begin
      f_early = $signed(fall0_i);
      f_late  = $signed(fall1_i);
    end
    d_pr = r_late - r_early;
    d_pf = f_late - f_early;
    if (f_late > r_late) begin
      d_hi = f_early - r_early;
      d_lo = r_late - f_early;
    end else begin
      d_hi = f_late - r_early;
      d_lo = r_early - f_early;
    end
    any_set = |{rise0_i, rise1_i, fall0_i, fall1_i};
  end

  always_ff @(posedge clk) begin
    if (rst || !any_set) begin
      per_rise_o <= '0;
      per_fall_o <= '0;
      high_o     <= '0;
      low_o      <= '0;
      ready_o    <= 1'b0;
    end else begin
      per_rise_o <= nonneg(d_pr);
      per_fall_o <= nonneg(d_pf);
      high_o     <= nonneg(d_hi);
      low_o      <= nonneg(d_lo);
      ready_o    <= 1'b1;
    end
  end

  assert_nonneg_R11: assert property (@(posedge clk) disable iff (rst)
    !per_rise_o[TS_W-1] && !per_fall_o[TS_W-1] && !high_o[TS_W-1] && !low_o[TS_W-1]);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (per_rise_o == '0) && (per_fall_o == '0) && (high_o == '0) && (low_o == '0));
  assert_ready_follows_R7: assert property (@(posedge clk) disable iff (rst)
    $past(any_set) |-> ready_o);
endmodule

// File: rtl/dual_edge_pulse_timer.sv
module dual_edge_pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int OVF_W = DEF_OVF_W,
  parameter int EC_W  = DEF_EC_W,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2,
  localparam int TS_W = CNT_W + OVF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sig_async_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic [EC_W-1:0] rise_count_o,
  output logic [EC_W-1:0] fall_count_o,
  output logic [TS_W-1:0] period_rise_o,
  output logic [TS_W-1:0] period_fall_o,
  output logic [TS_W-1:0] high_time_o,
  output logic [TS_W-1:0] low_time_o,
  output logic            ready_o
);
  logic [TS_W-1:0] ts;
  edge_evt_t       evt;
  logic [TS_W-1:0] rise0, rise1, fall0, fall1;

  pt_timebase #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_timebase (
    .clk(clk), .rst(rst), .ts_o(ts));

  pt_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst(rst), .sig_i(sig_async_i), .evt_o(evt));

  pt_capture_chan #(.TS_W(TS_W), .EC_W(EC_W)) u_rise_chan (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .evt_i(evt.rise), .ts_i(ts),
    .slot0_o(rise0), .slot1_o(rise1), .count_o(rise_count_o));

  pt_capture_chan #(.TS_W(TS_W), .EC_W(EC_W)) u_fall_chan (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .evt_i(evt.fall), .ts_i(ts),
    .slot0_o(fall0), .slot1_o(fall1), .count_o(fall_count_o));

  pt_interval_calc #(.TS_W(TS_W)) u_calc (
    .clk(clk), .rst(rst),
    .rise0_i(rise0), .rise1_i(rise1), .fall0_i(fall0), .fall1_i(fall1),
    .per_rise_o(period_rise_o), .per_fall_o(period_fall_o),
    .high_o(high_time_o), .low_o(low_time_o), .ready_o(ready_o));
endmodule

// File: tb/test_dual_edge_pulse_timer.sv
module test_dual_edge_pulse_timer;
  localparam int CNT_W = 8;
  localparam int OVF_W = 24;
  localparam int EC_W  = 8;
  localparam int TS_W  = CNT_W + OVF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic [EC_W-1:0] rc, fc;
  logic [TS_W-1:0] pr, pf, hi, lo;
  logic rdy;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dual_edge_pulse_timer #(.CNT_W(CNT_W), .OVF_W(OVF_W), .EC_W(EC_W)) i_dual_edge_pulse_timer (
    .clk(clk), .rst(rst), .sig_async_i(sig), .start_i(start), .stop_i(stop),
    .rise_count_o(rc), .fall_count_o(fc),
    .period_rise_o(pr), .period_fall_o(pf),
    .high_time_o(hi), .low_time_o(lo), .ready_o(rdy));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sig = 1'b0;
    wait_cyc(12);
    start = 1'b1;
    wait_cyc(1);
    start = 1'b0;
    wait_cyc(1);
    chk("R5 rise count cleared", rc, 0);
    chk("R5 fall count cleared", fc, 0);
    chk("R7 ready low after start", rdy, 0);
  endtask

  // end_on_rise=0: last edge a fall (R9 path); 1: extra rise (R10 path)
  task automatic run_wave(input int p, input int h, input bit end_on_rise);
    do_start();
    for (int k = 0; k < 3; k++) begin
      sig = 1'b1;
      wait_cyc(h);
      sig = 1'b0;
      wait_cyc(p - h);
    end
    if (end_on_rise) sig = 1'b1;
    wait_cyc(12);
    chk("R7 ready", rdy, 1);
    chk("R4 rise count", rc, end_on_rise ? 4 : 3);
    chk("R4 fall count", fc, 3);
    chk("R1 R3 R8 rise period", pr, p);
    chk("R1 R3 R8 fall period", pf, p);
    if (end_on_rise) begin
      chk("R10 high time", hi, h);
      chk("R10 low time", lo, p - h);
    end else begin
      chk("R9 high time", hi, h);
      chk("R9 low time", lo, p - h);
    end
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    chk("R7 reset ready", rdy, 0);
    chk("R4 reset rise count", rc, 0);
    chk("R7 reset period", pr, 0);

    // sweep of periods and duty cycles; phases vs. wrap vary throughout
    for (int p = 8; p <= 40; p += 4) begin
      for (int j = 0; j < 3; j++) begin
        int h;
        h = (j == 0) ? 3 : (j == 1) ? p / 2 : p - 3;
        run_wave(p, h, 1'b0);
        run_wave(p, h, 1'b1);
      end
    end
    // period longer than one full wrap of the base counter
    run_wave(300, 120, 1'b0);
    run_wave(300, 120, 1'b1);

    // R2: single-cycle glitches rejected, two-cycle pulse accepted
    do_start();
    for (int k = 0; k < 3; k++) begin
      sig = 1'b1; wait_cyc(1); sig = 1'b0; wait_cyc(6);
    end
    wait_cyc(8);
    chk("R2 glitch no rise", rc, 0);
    chk("R2 glitch no fall", fc, 0);
    sig = 1'b1; wait_cyc(2); sig = 1'b0; wait_cyc(12);
    chk("R2 two-cycle rise", rc, 1);
    chk("R2 two-cycle fall", fc, 1);

    // R11 / R7: single rising edge only
    do_start();
    sig = 1'b1;
    wait_cyc(12);
    chk("R7 ready single rise", rdy, 1);
    chk("R11 high zero", hi, 0);
    chk("R11 low zero", lo, 0);
    chk("R11 fall period zero", pf, 0);
    chk("R11 rise period sign", pr[TS_W-1], 0);

    // R6: stop disarms capture
    do_start();
    stop = 1'b1; wait_cyc(1); stop = 1'b0;
    for (int k = 0; k < 5; k++) begin
      sig = 1'b1; wait_cyc(5); sig = 1'b0; wait_cyc(5);
    end
    wait_cyc(12);
    chk("R6 rise count held", rc, 0);
    chk("R6 fall count held", fc, 0);
    chk("R6 ready stays low", rdy, 0);

    // R4: count wraps modulo 256
    do_start();
    for (int k = 0; k < 260; k++) begin
      sig = 1'b1; wait_cyc(4); sig = 1'b0; wait_cyc(4);
    end
    wait_cyc(12);
    chk("R4 rise count wrap", rc, 4);
    chk("R4 fall count wrap", fc, 4);
    chk("R8 period after wrap", pr, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule